// File: doc/BRIEF.md
# Event Block Word Formatter

This block turns one triggered event into a self-describing stream of 32-bit words. A single `start` pulse latches the slot number, block number, event number, a 48-bit trigger timestamp, a channel enable mask and a sample count for each channel. The formatter then emits, in order: a block header, an event header, two trigger-time words, and for each enabled channel in ascending order a window header followed by sample words. It closes the block with a trailer that holds the total word count. Each block holds exactly one event. The samples arrive on a separate valid/ready input as one flat stream. It carries the samples of the enabled channels in channel order, and no sample comes from a disabled channel. The words leave on a valid/ready output.

Every word that defines a type has bit 31 set and a 4-bit type code in bits 30:27. The codes are 0 for the block header, 1 for the trailer, 2 for the event header, 3 for trigger time and 4 for a window header. Sample words and the second trigger-time word have bit 31 clear.

A state machine sequences the block through these states:

- IDLE goes to BHDR on `start`.
- BHDR, EHDR, TLO and THI each advance to the next state once their word is emitted. THI leads to SCAN.
- SCAN goes to TRAIL once every channel has been visited. It goes to WHDR for an enabled channel. For a disabled channel it steps to the next channel and stays in SCAN.
- WHDR goes back to SCAN when the count is zero, and to SMPA otherwise.
- In SMPA, when one sample is left, the state emits a padded word and returns to SCAN. Otherwise it holds the sample and moves to SMPB.
- SMPB emits a pair. It returns to SCAN on the last sample and to SMPA otherwise.
- TRAIL goes back to IDLE.

Top module: `efmt_block_formatter`

## Requirements
- R1: After reset `out_valid`, `busy` and `smp_ready` are all 0.
- R2: The first word of a block is the block header. Bit 31 is 1, bits 30:27 are 0, bits 26:22 hold the slot, bits 21:18 are 0, bits 17:8 hold the block number and bits 7:0 hold the event count, which is always 1. For slot 4 the top byte is 0x81.
- R3: The second word is the event header. Bit 31 is 1, bits 30:27 are 2, bits 26:22 are 0 and bits 21:0 hold the event number.
- R4: The next two words carry the timestamp. The third word has bit 31 set, type 3, bits 26:24 zero and timestamp bits 23:0 in bits 23:0. The fourth word has bits 31:24 zero and timestamp bits 47:24 in bits 23:0.
- R5: Each enabled channel, in ascending channel order, yields a window header. Bit 31 is 1, bits 30:27 are 4, bits 26:23 hold the channel, bits 22:12 are 0 and bits 11:0 hold the sample count. Disabled channels yield no words. For example, channel 5 with 38 samples gives 0xA2800026.
- R6: A sample word has bits 31:30 zero. The earlier sample sits in bits 28:16 and the later one in bits 12:0. Bits 15:14 are zero. The invalid flags at bit 29 and bit 13 are 0 for real samples.
- R7: For an odd count, the last sample word carries the final sample in bits 28:16 with bit 29 clear. Bit 13 is set and bits 12:0 are zero.
- R8: An enabled channel with a zero count yields its window header and no sample words.
- R9: The last word is the trailer. Bit 31 is 1, bits 30:27 are 1, bits 26:22 hold the slot and bits 21:0 hold the number of words in the block, header and trailer included.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady. Under any ready pattern, every word is delivered exactly once and in order.
- R11: A `start` pulse while `busy` is 1 has no effect. The block in progress completes unchanged, and no further words follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; configuration inputs are latched on this cycle |
| slot | input | 5 | Slot number for header and trailer |
| blk_num | input | 10 | Block number for the block header |
| evt_num | input | 22 | Event number for the event header |
| trig_time | input | 48 | Trigger timestamp |
| ch_enable | input | NCH | One bit per channel; 1 means the channel is formatted |
| ch_count | input | NCH*CNTW | Sample count per channel, channel i at bits i*CNTW upward |
| busy | output | 1 | A block is being formatted |
| smp_valid | input | 1 | Sample input valid |
| smp_ready | output | 1 | Sample input accepted this cycle when valid |
| smp_data | input | 13 | Sample value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |

## Verification
The hardest situation to reach from the ports is a pair of samples completed in SMPB while the output register is still blocked. In that state the second sample must wait, and must not be taken, until the held word drains. The bench reaches it by combining a periodic `out_ready` pattern with gaps in the sample source, over channels of several odd and even counts. It then compares the collected stream word by word against a model built from the requirements. A second path that is hard to reach is a `start` arriving mid-block. The bench fires one during the sample phase with a different slot and checks the stream and the trailer slot afterwards.

// File: rtl/efmt_pkg.sv
package efmt_pkg;

    typedef enum logic [3:0] {
        WT_BLK_HDR = 4'd0,
        WT_BLK_TRL = 4'd1,
        WT_EVT_HDR = 4'd2,
        WT_TRIG    = 4'd3,
        WT_WIN_HDR = 4'd4
    } wtype_e;

    typedef enum logic [3:0] {
        S_IDLE, S_BHDR, S_EHDR, S_TLO, S_THI,
        S_SCAN, S_WHDR, S_SMPA, S_SMPB, S_TRAIL
    } fmt_state_e;

    localparam int SMP_W = 13;

    function automatic logic [31:0] typed_word(wtype_e t, logic [26:0] body);
        return {1'b1, t, body};
    endfunction

endpackage

// File: rtl/efmt_out_stage.sv
module efmt_out_stage (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        emit,
    input  logic [31:0] word,
    output logic        load,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);
    assign load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_data  <= word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/efmt_word_counter.sv
module efmt_word_counter #(
    parameter int WCW = 22
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           inc,
    output logic [WCW-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (clear)  value <= '0;
        else if (inc)    value <= value + WCW'(1);
    end
endmodule

// File: rtl/efmt_block_formatter.sv
module efmt_block_formatter
    import efmt_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CNTW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4:0]          slot,
    input  logic [9:0]          blk_num,
    input  logic [21:0]         evt_num,
    input  logic [47:0]         trig_time,
    input  logic [NCH-1:0]      ch_enable,
    input  logic [NCH*CNTW-1:0] ch_count,
    output logic                busy,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [12:0]         smp_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [31:0]         out_data
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CIW = $clog2(NCH + 1);
    localparam int WCW = 22;

    fmt_state_e st, nxt;

    logic [4:0]       slot_l;
    logic [9:0]       blk_l;
    logic [21:0]      evt_l;
    logic [47:0]      ts_l;
    logic [NCH-1:0]   en_l;
    logic [CNTW-1:0]  cnt_a [NCH];
    logic [CIW-1:0]   ch;
    logic [CNTW-1:0]  rem;
    logic [SMP_W-1:0] hold;
    logic [WCW-1:0]   wc;

    logic        emit, load, accept;
    logic        hold_ld, rem_ld, rem_dec, ch_inc;
    logic [31:0] word;
    logic [CHW-1:0]  chi;
    logic [CNTW-1:0] cur_cnt;
    logic [3:0]      ch_field;

    assign accept   = (st == S_IDLE) && start;
    assign busy     = (st != S_IDLE);
    assign chi      = ch[CHW-1:0];
    assign cur_cnt  = cnt_a[chi];
    assign ch_field = 4'(ch);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Next state and outputs
    always_comb begin
        nxt       = st;
        emit      = 1'b0;
        word      = '0;
        smp_ready = 1'b0;
        hold_ld   = 1'b0;
        rem_ld    = 1'b0;
        rem_dec   = 1'b0;
        ch_inc    = 1'b0;
        unique case (st)
            S_IDLE: if (start) nxt = S_BHDR;
            S_BHDR: begin
                word = typed_word(WT_BLK_HDR, {slot_l, 4'd0, blk_l, 8'd1});
                if (load) begin emit = 1'b1; nxt = S_EHDR; end
            end
            S_EHDR: begin
                word = typed_word(WT_EVT_HDR, {5'd0, evt_l});
                if (load) begin emit = 1'b1; nxt = S_TLO; end
            end
            S_TLO: begin
                word = typed_word(WT_TRIG, {3'd0, ts_l[23:0]});
                if (load) begin emit = 1'b1; nxt = S_THI; end
            end
            S_THI: begin
                word = {8'd0, ts_l[47:24]};
                if (load) begin emit = 1'b1; nxt = S_SCAN; end
            end
            S_SCAN: begin
                if (ch == CIW'(NCH))  nxt = S_TRAIL;
                else if (en_l[chi])   nxt = S_WHDR;
                else                  ch_inc = 1'b1;
            end
            S_WHDR: begin
                word = typed_word(WT_WIN_HDR, {ch_field, 11'd0, 12'(cur_cnt)});
                if (load) begin
                    emit   = 1'b1;
                    rem_ld = 1'b1;
                    if (cur_cnt == '0) begin ch_inc = 1'b1; nxt = S_SCAN; end
                    else               nxt = S_SMPA;
                end
            end
            S_SMPA: begin
                word = {3'b000, smp_data, 2'b00, 1'b1, 13'd0};
                if (rem == CNTW'(1)) begin
                    smp_ready = load;
                    if (load && smp_valid) begin
                        emit = 1'b1; ch_inc = 1'b1; nxt = S_SCAN;
                    end
                end else begin
                    smp_ready = 1'b1;
                    if (smp_valid) begin
                        hold_ld = 1'b1; rem_dec = 1'b1; nxt = S_SMPB;
                    end
                end
            end
            S_SMPB: begin
                word      = {3'b000, hold, 2'b00, 1'b0, smp_data};
                smp_ready = load;
                if (load && smp_valid) begin
                    emit    = 1'b1;
                    rem_dec = 1'b1;
                    if (rem == CNTW'(1)) begin ch_inc = 1'b1; nxt = S_SCAN; end
                    else                 nxt = S_SMPA;
                end
            end
            S_TRAIL: begin
                word = typed_word(WT_BLK_TRL, {slot_l, wc + WCW'(1)});
                if (load) begin emit = 1'b1; nxt = S_IDLE; end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_l <= '0; blk_l <= '0; evt_l <= '0; ts_l <= '0;
            en_l <= '0; ch <= '0; rem <= '0; hold <= '0;
        end else begin
            if (accept) begin
                slot_l <= slot; blk_l <= blk_num; evt_l <= evt_num;
                ts_l <= trig_time; en_l <= ch_enable; ch <= '0;
            end else if (ch_inc) begin
                ch <= ch + CIW'(1);
            end
            if (rem_ld)       rem <= cur_cnt;
            else if (rem_dec) rem <= rem - CNTW'(1);
            if (hold_ld)      hold <= smp_data;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt_a[i] <= '0;
            else if (accept) cnt_a[i] <= ch_count[i*CNTW +: CNTW];
        end
    end

    efmt_word_counter #(.WCW(WCW)) u_wc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .inc(emit), .value(wc)
    );

    efmt_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .emit(emit), .word(word), .load(load),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );
endmodule

// File: rtl/efmt_checker.sv
module efmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        smp_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data
);
    // R10: a blocked word holds steady
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R11: a block only begins from a start request
    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: samples are only taken while a block is in progress
    assert_smp_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> busy);

    // R7: the earlier sample of a data word is never a padding sample
    assert_upper_real_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_data[31] |-> !out_data[29]);

    // R2: only defined type codes appear
    assert_type_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data[31] |-> out_data[30:27] <= 4'd4);
endmodule

bind efmt_block_formatter efmt_checker u_efmt_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .smp_ready(smp_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/efmt_block_formatter_test.sv
module efmt_block_formatter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int CNTW = 12;
    localparam int MAXW = 1024;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [4:0]          slot = '0;
    logic [9:0]          blk_num = '0;
    logic [21:0]         evt_num = '0;
    logic [47:0]         trig_time = '0;
    logic [NCH-1:0]      ch_enable = '0;
    logic [NCH*CNTW-1:0] ch_count = '0;
    logic                busy;
    logic                smp_valid = 1'b0;
    logic                smp_ready;
    logic [12:0]         smp_data = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [31:0]         out_data;

    efmt_block_formatter #(.NCH(NCH), .CNTW(CNTW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .slot(slot), .blk_num(blk_num),
        .evt_num(evt_num), .trig_time(trig_time), .ch_enable(ch_enable),
        .ch_count(ch_count), .busy(busy), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    int ready_mode = 0, gap_mode = 0;
    logic [12:0] src [MAXW];
    int src_n = 0, src_i = 0;
    logic [31:0] rx [MAXW];
    int rx_n = 0;
    logic [31:0] expw [MAXW];
    string etag [MAXW];
    int exp_n = 0;
    int stab_err = 0;
    logic prev_hold = 1'b0;
    logic [31:0] prev_word = '0;
    int cfg_cnt [NCH];
    logic [NCH-1:0] cfg_en;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp_v);
        end
    endtask

    // Drive source and ready, monitor the output, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (ready_mode == 0) ? 1'b1 : (((cyc * 7) % 5) < 3);
            smp_valid = (src_i < src_n) && (gap_mode == 0 || (cyc % 3) != 0);
            smp_data  = (src_i < src_n) ? src[src_i] : 13'd0;
            #1;
            if (prev_hold && (!out_valid || out_data !== prev_word)) stab_err++;
            prev_hold = out_valid && !out_ready;
            prev_word = out_data;
            if (out_valid && out_ready && rx_n < MAXW) begin
                rx[rx_n] = out_data;
                rx_n++;
            end
            if (smp_valid && smp_ready) src_i++;
        end
    end

    function automatic logic [12:0] sval(input int c, input int i);
        return 13'(c * 97 + i * 13 + 5) | ((i % 2 == 1) ? 13'h1000 : 13'h0);
    endfunction

    task automatic push_exp(input logic [31:0] w, input string t);
        expw[exp_n] = w; etag[exp_n] = t; exp_n++;
    endtask

    // Expected stream built from the requirements
    task automatic build(input logic [4:0] s, input logic [9:0] b, input logic [21:0] e,
                         input logic [47:0] ts);
        exp_n = 0; src_n = 0; src_i = 0; rx_n = 0; stab_err = 0;
        push_exp({1'b1, 4'd0, s, 4'd0, b, 8'd1}, "R2");
        push_exp({1'b1, 4'd2, 5'd0, e}, "R3");
        push_exp({1'b1, 4'd3, 3'd0, ts[23:0]}, "R4");
        push_exp({8'd0, ts[47:24]}, "R4");
        for (int c = 0; c < NCH; c++) begin
            if (cfg_en[c]) begin
                push_exp({1'b1, 4'd4, 4'(c), 11'd0, 12'(cfg_cnt[c])}, (cfg_cnt[c] == 0) ? "R8" : "R5");
                for (int i = 0; i < cfg_cnt[c]; i++) begin
                    src[src_n] = sval(c, i); src_n++;
                end
                for (int i = 0; i + 1 < cfg_cnt[c]; i += 2)
                    push_exp({3'b000, sval(c, i), 3'b000, sval(c, i + 1)}, "R6");
                if (cfg_cnt[c] % 2 == 1)
                    push_exp({3'b000, sval(c, cfg_cnt[c] - 1), 3'b001, 13'd0}, "R7");
            end
        end
        push_exp({1'b1, 4'd1, s, 22'(exp_n + 1)}, "R9");
        src_n = src_n; // source armed
    endtask

    task automatic run_block(input logic [4:0] s, input logic [9:0] b, input logic [21:0] e,
                             input logic [47:0] ts, input bit mid_start);
        logic [NCH*CNTW-1:0] cc;
        build(s, b, e, ts);
        cc = '0;
        for (int c = 0; c < NCH; c++) cc[c*CNTW +: CNTW] = CNTW'(cfg_cnt[c]);
        @(negedge clk);
        slot = s; blk_num = b; evt_num = e; trig_time = ts;
        ch_enable = cfg_en; ch_count = cc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        slot = 5'd31; blk_num = '1; evt_num = '1; trig_time = '1; ch_enable = '0; ch_count = '0;
        if (mid_start) begin
            repeat (12) @(negedge clk);
            slot = 5'd9; ch_enable = '1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            #2;
            if (!busy && !out_valid) break;
        end
        chk(rx_n == exp_n, "R10 word count", 32'(rx_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < rx_n; i++)
            chk(rx[i] === expw[i], etag[i], rx[i], expw[i]);
    endtask

    task automatic clear_cfg();
        cfg_en = '0;
        for (int c = 0; c < NCH; c++) cfg_cnt[c] = 0;
    endtask

    task automatic test_reset();
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(smp_ready == 1'b0, "R1 smp_ready", 32'(smp_ready), 0);
    endtask

    task automatic test_example();
        clear_cfg();
        ready_mode = 0; gap_mode = 0;
        cfg_en[5] = 1'b1; cfg_cnt[5] = 38;
        run_block(5'd4, 10'd1, 22'd8, 48'h00D1E17AEEF118, 1'b0);
        chk(rx[0][31:24] == 8'h81, "R2 slot 4 top byte", 32'(rx[0][31:24]), 32'h81);
        chk(rx[4] == 32'hA2800026, "R5 window header ch5/38", rx[4], 32'hA2800026);
        chk(rx[rx_n-1] == 32'h89000019, "R9 trailer 25 words", rx[rx_n-1], 32'h89000019);
    endtask

    task automatic test_mixed();
        clear_cfg();
        ready_mode = 0; gap_mode = 0;
        cfg_en[1] = 1'b1;  cfg_cnt[1] = 3;
        cfg_en[3] = 1'b1;  cfg_cnt[3] = 0;
        cfg_cnt[4] = 7;    // disabled: no words (R5)
        cfg_en[9] = 1'b1;  cfg_cnt[9] = 4;
        cfg_en[15] = 1'b1; cfg_cnt[15] = 1;
        run_block(5'd17, 10'd513, 22'h2ABCDE, 48'hFEDCBA987654, 1'b0);
    endtask

    task automatic test_backpressure();
        clear_cfg();
        ready_mode = 1; gap_mode = 1;
        for (int c = 0; c < NCH; c += 2) begin
            cfg_en[c] = 1'b1; cfg_cnt[c] = c + 1;
        end
        run_block(5'd2, 10'd7, 22'd123456, 48'h123456789ABC, 1'b0);
        chk(stab_err == 0, "R10 held word stable", 32'(stab_err), 0);
    endtask

    task automatic test_empty();
        clear_cfg();
        ready_mode = 1; gap_mode = 0;
        run_block(5'd0, 10'd0, 22'd0, 48'd0, 1'b0);
        chk(rx[rx_n-1] == 32'h88000005, "R9 empty block trailer", rx[rx_n-1], 32'h88000005);
    endtask

    task automatic test_restart_ignored();
        clear_cfg();
        ready_mode = 1; gap_mode = 1;
        cfg_en[0] = 1'b1; cfg_cnt[0] = 10;
        cfg_en[6] = 1'b1; cfg_cnt[6] = 5;
        run_block(5'd4, 10'd3, 22'd99, 48'h0000AAAA5555, 1'b1);
        repeat (20) @(negedge clk);
        #2;
        chk(rx_n == exp_n, "R11 no extra words after block", 32'(rx_n), 32'(exp_n));
        chk(busy == 1'b0, "R11 idle after block", 32'(busy), 0);
    endtask

    bit done = 0;
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clear_cfg();
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_example();
        test_mixed();
        test_backpressure();
        test_empty();
        test_restart_ignored();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule